// File: doc/BRIEF.md
# Parallel Bitonic Key Sorter

This block takes a vector of N unsigned keys, all presented in the same cycle, and returns the same keys in ascending order. N must be a power of two. The block is a fixed network of compare-exchange cells arranged in columns. Every cell compares two lanes whose indices differ in exactly one bit.

The first part of the network builds a single bitonic sequence. It sorts sub-blocks of growing size in alternating directions: 2, then 4, and so on up to N/2. The direction of each sub-block comes from one bit of its lane index. The last part is an ascending merge over the whole vector, and it uses only increasing cells. For N = 2^K the network has K(K+1)/2 columns.

A parameter chooses between two forms. The first puts a register after every column: it accepts one vector per cycle, and a valid flag travels with the data. The second has no registers and is purely combinational.

Top module: `bitonic_sorter`

## Requirements
- R1: When `out_valid` is high, the keys on `out_keys` are in ascending order of lane index. Lane i occupies bits [i*W +: W], and lane 0 holds the smallest key.
- R2: Each output vector holds exactly the same keys as its input vector, duplicates included. Only their positions change.
- R3: With PIPE=1, each vector accepted with `in_valid` high appears on `out_valid`/`out_keys` exactly K(K+1)/2 cycles later, in the order the vectors were accepted. `out_valid` is never high without a matching input. With PIPE=0, the outputs follow the inputs in the same cycle.
- R4: While `rst_n` is low, and after its release until the first vector has crossed the network, `out_valid` is low.
- R5: Equal keys are sorted correctly, including vectors made of only two distinct values and vectors in which every key is the same.
- R6: A new vector may be accepted on every cycle. Idle cycles (`in_valid` low) between vectors do not disturb the vectors already in flight.
- R7: The extreme key values 0 and 2^W-1 are sorted correctly when mixed with each other and with other keys.
- R8: Inputs that are already ascending, and inputs that are strictly descending, both come out ascending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers capture on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the pipeline |
| in_valid | input | 1 | High when `in_keys` carries a vector to sort |
| in_keys | input | N*W | N unsigned keys; lane i is at bits [i*W +: W] |
| out_valid | output | 1 | High when `out_keys` carries a sorted vector |
| out_keys | output | N*W | Sorted keys; lane 0 holds the smallest key |

## Verification
Certain inputs reach compare-exchange cells deep in the network only through one narrow set of lane patterns: heavy ties, and ones spread across sub-blocks that sort in opposite directions. A direction error in such a cell is therefore hard to provoke. The stimulus applies the zero-one principle and drives every one of the 2^16 patterns of two key values back to back. This covers every ordering the network can distinguish. Random vectors with gaps in `in_valid`, plus fixed extreme, sorted and reversed vectors, then check the valid pipeline and the wider key values.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    // Integer base-2 logarithm of a power of two.
    function automatic int log2i(input int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    // Number of comparator columns of the complete sorter for N = 2^k.
    function automatic int col_count(input int k);
        return (k * (k + 1)) / 2;
    endfunction

    // Flat column index of merge step t inside merge stage s (s from 1).
    function automatic int col_index(input int s, input int t);
        return ((s - 1) * s) / 2 + t;
    endfunction

endpackage

// File: rtl/bsort_cmpx.sv
module bsort_cmpx #(
    parameter int W   = 8,
    parameter bit ASC = 1'b1
) (
    input  logic [W-1:0] a_i,   // lane with the lower index
    input  logic [W-1:0] b_i,   // lane with the higher index
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);
    logic swap;

    always_comb begin
        // Ascending: smaller key goes to the lower lane; descending: reverse.
        swap = ASC ? (a_i > b_i) : (a_i < b_i);
        lo_o = swap ? b_i : a_i;
        hi_o = swap ? a_i : b_i;
    end
endmodule

// File: rtl/bsort_column.sv
module bsort_column #(
    parameter int N      = 16,
    parameter int W      = 8,
    parameter int DIST   = 1,   // lane distance of every pair in this column
    parameter int DIRBIT = 1,   // lane-index bit that selects the direction
    parameter bit REG    = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  logic [N*W-1:0] keys_i,
    output logic           vld_o,
    output logic [N*W-1:0] keys_o
);
    logic [N*W-1:0] net;

    for (genvar i = 0; i < N; i++) begin : g_lane
        if (((i / DIST) % 2) == 0) begin : g_pair
            localparam bit ASC = (((i >> DIRBIT) & 1) == 0);
            bsort_cmpx #(.W(W), .ASC(ASC)) u_cmpx (
                .a_i  (keys_i[i*W +: W]),
                .b_i  (keys_i[(i+DIST)*W +: W]),
                .lo_o (net[i*W +: W]),
                .hi_o (net[(i+DIST)*W +: W])
            );
        end
    end

    if (REG) begin : g_reg
        typedef struct packed {
            logic           vld;
            logic [N*W-1:0] keys;
        } col_t;

        col_t col_d, col_q;

        always_comb begin
            col_d      = col_q;
            col_d.vld  = vld_i;
            col_d.keys = net;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) col_q <= '0;
            else        col_q <= col_d;
        end

        assign vld_o  = col_q.vld;
        assign keys_o = col_q.keys;
    end else begin : g_comb
        assign vld_o  = vld_i;
        assign keys_o = net;
    end
endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter
    import bsort_pkg::*;
#(
    parameter int N    = 16,
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_keys,
    output logic           out_valid,
    output logic [N*W-1:0] out_keys
);
    localparam int K    = log2i(N);
    localparam int COLS = col_count(K);
    localparam int LAT  = PIPE ? COLS : 0;

    logic [N*W-1:0] chain_keys [COLS+1];
    logic           chain_vld  [COLS+1];

    assign chain_keys[0] = in_keys;
    assign chain_vld[0]  = in_valid;

    // Stage s merges blocks of 2^s lanes; step t pairs lanes 2^(s-1-t) apart.
    for (genvar s = 1; s <= K; s++) begin : g_stage
        for (genvar t = 0; t < s; t++) begin : g_step
            localparam int C    = col_index(s, t);
            localparam int DIST = 1 << (s - 1 - t);
            bsort_column #(
                .N(N), .W(W), .DIST(DIST), .DIRBIT(s), .REG(PIPE)
            ) u_col (
                .clk    (clk),
                .rst_n  (rst_n),
                .vld_i  (chain_vld[C]),
                .keys_i (chain_keys[C]),
                .vld_o  (chain_vld[C+1]),
                .keys_o (chain_keys[C+1])
            );
        end
    end

    assign out_valid = chain_vld[COLS];
    assign out_keys  = chain_keys[COLS];
endmodule

// File: rtl/bsort_checks.sv
module bsort_checks #(
    parameter int N   = 16,
    parameter int W   = 8,
    parameter int LAT = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N*W-1:0] in_keys,
    input logic           out_valid,
    input logic [N*W-1:0] out_keys
);
    localparam int SW = W + $clog2(N) + 1;

    logic [SW-1:0] in_sum, out_sum;
    logic [W-1:0]  in_xor, out_xor;
    logic          ordered;

    always_comb begin
        in_sum  = '0;
        out_sum = '0;
        in_xor  = '0;
        out_xor = '0;
        ordered = 1'b1;
        for (int i = 0; i < N; i++) begin
            in_sum  = in_sum  + SW'(in_keys[i*W +: W]);
            out_sum = out_sum + SW'(out_keys[i*W +: W]);
            in_xor  = in_xor  ^ in_keys[i*W +: W];
            out_xor = out_xor ^ out_keys[i*W +: W];
        end
        for (int i = 0; i + 1 < N; i++) begin
            if (out_keys[i*W +: W] > out_keys[(i+1)*W +: W]) ordered = 1'b0;
        end
    end

    p_sorted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ordered);

    if (LAT > 0) begin : g_seq
        logic [LAT-1:0] vld_sh;
        logic [SW-1:0]  sum_sh [LAT];
        logic [W-1:0]   xor_sh [LAT];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_sh <= '0;
                for (int i = 0; i < LAT; i++) begin
                    sum_sh[i] <= '0;
                    xor_sh[i] <= '0;
                end
            end else begin
                vld_sh[0] <= in_valid;
                sum_sh[0] <= in_sum;
                xor_sh[0] <= in_xor;
                for (int i = 1; i < LAT; i++) begin
                    vld_sh[i] <= vld_sh[i-1];
                    sum_sh[i] <= sum_sh[i-1];
                    xor_sh[i] <= xor_sh[i-1];
                end
            end
        end

        p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == vld_sh[LAT-1]);

        p_sum_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_sum == sum_sh[LAT-1]));

        p_xor_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_xor == xor_sh[LAT-1]));

        p_reset_idle_r4: assert property (@(posedge clk)
            !rst_n |=> !out_valid);
    end else begin : g_comb
        p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);

        p_sum_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_sum == in_sum));

        p_xor_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_xor == in_xor));
    end
endmodule

bind bitonic_sorter bsort_checks #(.N(N), .W(W), .LAT(LAT)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_keys   (in_keys),
    .out_valid (out_valid),
    .out_keys  (out_keys)
);

// File: tb/bitonic_sorter_tb.sv
module bitonic_sorter_tb;
    localparam int N   = 16;
    localparam int W   = 8;
    localparam int LAT = 10;   // 4*5/2 columns for N = 16

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_keys = '0;
    logic           out_valid;
    logic [N*W-1:0] out_keys;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [N*W-1:0] exp_q [$];
    int             cyc_q [$];
    string          tag_q [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bitonic_sorter #(.N(N), .W(W), .PIPE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_keys(in_keys),
        .out_valid(out_valid), .out_keys(out_keys)
    );

    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        logic [W-1:0] a [N];
        logic [W-1:0] tmp;
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
        for (int p = 0; p < N; p++)
            for (int i = 0; i + 1 < N - p; i++)
                if (a[i] > a[i+1]) begin
                    tmp = a[i]; a[i] = a[i+1]; a[i+1] = tmp;
                end
        for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic sample_out();
        logic [N*W-1:0] e;
        int c;
        string t;
        if (out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 spurious out_valid", "1", "0");
            end else begin
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                check(out_keys == e, t, $sformatf("%h", out_keys), $sformatf("%h", e));
                check((cyc - c) == LAT, "R3 latency",
                      $sformatf("%0d", cyc - c), $sformatf("%0d", LAT));
            end
        end
    endtask

    task automatic step(input logic vld, input logic [N*W-1:0] keys, input string tag);
        @(negedge clk);
        sample_out();
        in_valid = vld;
        in_keys  = keys;
        if (vld) begin
            exp_q.push_back(ref_sort(keys));
            cyc_q.push_back(cyc);
            tag_q.push_back(tag);
        end
    endtask

    function automatic logic [N*W-1:0] ramp(input bit down);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++)
            r[i*W +: W] = W'(down ? (N - i) * 9 : i * 9 + 1);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] v;
        // R4: idle during and right after reset
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R4 in reset", $sformatf("%b", out_valid), "0");
        rst_n = 1'b1;
        repeat (LAT + 2) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R4 after release", $sformatf("%b", out_valid), "0");
        end

        // R1 R2 R5 R6: every two-valued pattern, back to back (zero-one principle)
        for (int p = 0; p < (1 << N); p++) begin
            for (int i = 0; i < N; i++) v[i*W +: W] = p[i] ? 8'h5A : 8'h17;
            step(1'b1, v, "R1 R2 R5 R6 zero-one");
        end

        // R7: extremes mixed
        for (int p = 0; p < 64; p++) begin
            for (int i = 0; i < N; i++)
                v[i*W +: W] = ((p + i) % 3 == 0) ? 8'hFF : (((p ^ i) & 1) != 0 ? 8'h00 : W'(p * 7 + i));
            step(1'b1, v, "R7 extremes");
        end

        // R8 and R5: sorted, reversed, all equal
        step(1'b1, ramp(1'b0), "R8 ascending input");
        step(1'b1, ramp(1'b1), "R8 descending input");
        step(1'b1, {N{8'h33}}, "R5 all equal");
        step(1'b1, {N{8'hFF}}, "R7 all ones");
        step(1'b1, '0, "R7 all zeros");

        // R6 R1 R2: random keys with idle gaps
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
            step(($urandom % 4) != 0, v, "R1 R2 R6 random gaps");
        end

        // drain
        repeat (LAT + 3) step(1'b0, '0, "idle");
        check(exp_q.size() == 0, "R3 all vectors delivered",
              $sformatf("%0d", exp_q.size()), "0");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule